// File: doc/BRIEF.md
# Context-tagged fully-associative TLB lookup

A small fully-associative translation cache that holds virtual-to-physical mappings together with the context they belong to. Each entry records a page address, a page size, a physical page, an attribute byte, an address-space ID, a global flag, a virtual-machine ID and a two-bit memory-space tag. Mappings from many processes, guests and privilege levels coexist in the array. Only the tags decide which entry answers a lookup, so a context switch or a guest switch needs no flush.

A lookup is purely combinational. The request gives a 48-bit virtual address, its security state, its exception level, whether the top level runs in 64-bit mode, and the current address-space and virtual-machine IDs. In the same cycle the block returns a hit flag, the matching index, the translated physical address and the attributes. It also flags when more than one entry matched.

A write port fills the lowest-index free entry, or a round-robin victim when the array is full. An invalidate-all input and a single-entry invalidate input clear valid bits.

Top module: `ctx_tlb`

## Requirements
- R1: While reset is asserted and after its release, every entry is invalid, so `hit` and `multi_hit` are 0 and `pa_out` is 0.
- R2: An entry's address compare uses only VA bits [47:N]. The size code sets N: 0 gives 12 (4 KB), 1 gives 16 (64 KB), 2 gives 21 (2 MB) and 3 gives 30 (1 GB). Requests that differ only below bit N match; requests that differ at bit N or above miss.
- R3: On a hit, `pa_out` takes bits [47:N] from the entry's physical address and bits [N-1:0] from `lk_va`, and `attr_out` is the entry's attribute byte.
- R4: The request's memory space is derived as follows. `lk_el`=3 with `lk_top64`=1 gives 0. `lk_el`=3 with `lk_top64`=0 gives 2. `lk_el`=2 gives 1. `lk_el`=0 or 1 gives 2 when `lk_secure`=1 and 3 otherwise. A hit requires the entry's space tag (`wr_space` at fill) to equal this value.
- R5: For requests in space 2 or 3, the entry's ASID must equal `cur_asid`, unless the entry's global flag is set.
- R6: For requests in space 3, the entry's VMID must equal `cur_vmid`.
- R7: Requests in space 0 or 1 ignore both the ASID and the VMID.
- R8: Requests in space 2, including those from the 32-bit top level, check the ASID but ignore the VMID.
- R9: A fill goes to the lowest-index invalid entry. When all entries are valid, the fill goes to a round-robin pointer that starts at 0 after reset and advances by one, wrapping, on each such fill.
- R10: When several entries match, the lowest-index one supplies `hit_idx`, `pa_out` and `attr_out`, and `multi_hit` is 1. With exactly one match, `multi_hit` is 0.
- R11: `inv_all` clears every valid bit at the next edge and takes precedence over a fill in the same cycle, which is dropped.
- R12: `inv_one` clears entry `inv_idx` at the next edge. It is ignored in a cycle where `wr_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_va | input | 48 | Lookup virtual address |
| lk_secure | input | 1 | Request is in the secure state |
| lk_el | input | 2 | Request exception level |
| lk_top64 | input | 1 | Top level runs in 64-bit mode |
| cur_asid | input | 16 | Current address-space ID |
| cur_vmid | input | 8 | Current virtual-machine ID |
| wr_en | input | 1 | Fill one entry this cycle |
| wr_va | input | 48 | Fill virtual address |
| wr_size | input | 2 | Fill page-size code |
| wr_pa | input | 48 | Fill physical address |
| wr_attr | input | 8 | Fill memory attributes |
| wr_asid | input | 16 | Fill address-space ID |
| wr_global | input | 1 | Fill global flag |
| wr_vmid | input | 8 | Fill virtual-machine ID |
| wr_space | input | 2 | Fill memory-space tag |
| inv_all | input | 1 | Invalidate every entry |
| inv_one | input | 1 | Invalidate entry `inv_idx` |
| inv_idx | input | 4 | Entry to invalidate |
| hit | output | 1 | Some entry matched |
| multi_hit | output | 1 | More than one entry matched |
| hit_idx | output | 4 | Index of the winning entry |
| pa_out | output | 48 | Translated physical address |
| attr_out | output | 8 | Attributes of the winning entry |

## Verification
The bench probes an address one step past the page boundary for each of the four sizes. A design with a wrong shift would hit there, or would return the wrong offset bits in the physical address. It also sends the same address from every privilege level. A design that checked the VMID for secure or hypervisor requests, or that skipped the ASID for the 32-bit top level, would miss or hit where it should not. Overlapping large and small pages expose a wrong priority or a missing multi-hit flag. Filling past a freed slot and past a full array, and mixing invalidates with fills in the same cycle, expose a wrong victim or a wrong precedence, which shows up as a lost or misplaced entry.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  // request memory-space encodings (field value is part of the behaviour)
  typedef enum logic [1:0] {
    SPC_SEC_TOP64 = 2'd0,
    SPC_NS_HYP    = 2'd1,
    SPC_SEC_UK    = 2'd2,
    SPC_NS_UK     = 2'd3
  } space_e;

  localparam int unsigned MIN_SHIFT = 12;

  // log2 of the page size for a size code
  function automatic int unsigned page_shift(logic [1:0] code);
    case (code)
      2'd0:    return 12;
      2'd1:    return 16;
      2'd2:    return 21;
      default: return 30;
    endcase
  endfunction

  // ones in the low sh bits
  function automatic logic [63:0] low_ones(int unsigned sh);
    return (64'd1 << sh) - 64'd1;
  endfunction

  // memory space of a request
  function automatic space_e req_space(logic secure, logic [1:0] el, logic top64);
    if (el == 2'd3)      return top64 ? SPC_SEC_TOP64 : SPC_SEC_UK;
    else if (el == 2'd2) return SPC_NS_HYP;
    else                 return secure ? SPC_SEC_UK : SPC_NS_UK;
  endfunction

  function automatic logic skip_asid(space_e s);
    return (s == SPC_SEC_TOP64) || (s == SPC_NS_HYP);
  endfunction

  function automatic logic skip_vmid(space_e s);
    return s != SPC_NS_UK;
  endfunction

endpackage

// File: rtl/tlb_entry_cmp.sv
module tlb_entry_cmp
  import tlb_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int ASID_W = 16,
  parameter int VMID_W = 8
) (
  input  logic              e_valid,
  input  logic [ADDR_W-1:0] e_va,
  input  logic [1:0]        e_size,
  input  logic [ASID_W-1:0] e_asid,
  input  logic              e_glob,
  input  logic [VMID_W-1:0] e_vmid,
  input  logic [1:0]        e_spc,
  input  logic [ADDR_W-1:0] rq_va,
  input  space_e            rq_spc,
  input  logic [ASID_W-1:0] rq_asid,
  input  logic [VMID_W-1:0] rq_vmid,
  output logic              match
);

  logic [ADDR_W-1:0] off_mask;
  logic              va_eq;
  logic              spc_eq;
  logic              asid_ok;
  logic              vmid_ok;

  always_comb begin
    off_mask = ADDR_W'(low_ones(page_shift(e_size)));
    va_eq    = ((e_va ^ rq_va) & ~off_mask) == '0;
    spc_eq   = e_spc == rq_spc;
    asid_ok  = skip_asid(rq_spc) || e_glob || (e_asid == rq_asid);
    vmid_ok  = skip_vmid(rq_spc) || (e_vmid == rq_vmid);
    match    = e_valid && va_eq && spc_eq && asid_ok && vmid_ok;
  end

endmodule

// File: rtl/tlb_pick.sv
module tlb_pick #(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] match_vec,
  output logic               any_hit,
  output logic               many_hit,
  output logic [IDX_W-1:0]   win_idx
);

  always_comb begin
    any_hit = 1'b0;
    win_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match_vec[i]) begin
        any_hit = 1'b1;
        win_idx = IDX_W'(i);
      end
    end
    many_hit = |(match_vec & (match_vec - 1'b1));
  end

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic               fill_fire,
  output logic [IDX_W-1:0]   victim_idx,
  output logic               victim_free
);

  logic [IDX_W-1:0] rr_ptr;
  logic [IDX_W-1:0] free_idx;

  always_comb begin
    victim_free = 1'b0;
    free_idx    = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_vec[i]) begin
        victim_free = 1'b1;
        free_idx    = IDX_W'(i);
      end
    end
    victim_idx = victim_free ? free_idx : rr_ptr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rr_ptr <= '0;
    end else if (fill_fire && !victim_free) begin
      rr_ptr <= (rr_ptr == IDX_W'(ENTRIES - 1)) ? '0 : rr_ptr + 1'b1;
    end
  end

endmodule

// File: rtl/ctx_tlb.sv
module ctx_tlb
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int ADDR_W  = 48,
  parameter int ASID_W  = 16,
  parameter int VMID_W  = 8,
  parameter int ATTR_W  = 8,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] lk_va,
  input  logic              lk_secure,
  input  logic [1:0]        lk_el,
  input  logic              lk_top64,
  input  logic [ASID_W-1:0] cur_asid,
  input  logic [VMID_W-1:0] cur_vmid,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_va,
  input  logic [1:0]        wr_size,
  input  logic [ADDR_W-1:0] wr_pa,
  input  logic [ATTR_W-1:0] wr_attr,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic              wr_global,
  input  logic [VMID_W-1:0] wr_vmid,
  input  logic [1:0]        wr_space,
  input  logic              inv_all,
  input  logic              inv_one,
  input  logic [IDX_W-1:0]  inv_idx,
  output logic              hit,
  output logic              multi_hit,
  output logic [IDX_W-1:0]  hit_idx,
  output logic [ADDR_W-1:0] pa_out,
  output logic [ATTR_W-1:0] attr_out
);

  typedef struct packed {
    logic [ADDR_W-1:0] va;
    logic [1:0]        size;
    logic [ADDR_W-1:0] pa;
    logic [ATTR_W-1:0] attr;
    logic [ASID_W-1:0] asid;
    logic              glob;
    logic [VMID_W-1:0] vmid;
    logic [1:0]        spc;
  } ent_t;

  ent_t               tab [ENTRIES];
  logic [ENTRIES-1:0] valid_vec;
  logic [ENTRIES-1:0] match_vec;
  space_e             req_spc;
  logic [IDX_W-1:0]   victim_idx;
  logic               victim_free;
  logic               fill_fire;
  ent_t               win;

  // physical address: entry page bits above the page offset, request offset below
  function automatic logic [ADDR_W-1:0] merge_pa(logic [ADDR_W-1:0] page_pa,
                                                 logic [ADDR_W-1:0] va,
                                                 logic [1:0] code);
    logic [ADDR_W-1:0] m;
    m = ADDR_W'(low_ones(page_shift(code)));
    return (page_pa & ~m) | (va & m);
  endfunction

  assign req_spc   = req_space(lk_secure, lk_el, lk_top64);
  assign fill_fire = wr_en && !inv_all;

  generate
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      tlb_entry_cmp #(
        .ADDR_W(ADDR_W),
        .ASID_W(ASID_W),
        .VMID_W(VMID_W)
      ) u_cmp (
        .e_valid (valid_vec[g]),
        .e_va    (tab[g].va),
        .e_size  (tab[g].size),
        .e_asid  (tab[g].asid),
        .e_glob  (tab[g].glob),
        .e_vmid  (tab[g].vmid),
        .e_spc   (tab[g].spc),
        .rq_va   (lk_va),
        .rq_spc  (req_spc),
        .rq_asid (cur_asid),
        .rq_vmid (cur_vmid),
        .match   (match_vec[g])
      );
    end
  endgenerate

  tlb_pick #(
    .ENTRIES(ENTRIES),
    .IDX_W  (IDX_W)
  ) u_pick (
    .match_vec (match_vec),
    .any_hit   (hit),
    .many_hit  (multi_hit),
    .win_idx   (hit_idx)
  );

  tlb_victim #(
    .ENTRIES(ENTRIES),
    .IDX_W  (IDX_W)
  ) u_victim (
    .clk         (clk),
    .rst_n       (rst_n),
    .valid_vec   (valid_vec),
    .fill_fire   (fill_fire),
    .victim_idx  (victim_idx),
    .victim_free (victim_free)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_vec <= '0;
    end else if (inv_all) begin
      valid_vec <= '0;
    end else if (wr_en) begin
      valid_vec[victim_idx] <= 1'b1;
    end else if (inv_one) begin
      valid_vec[inv_idx] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_fire) begin
      tab[victim_idx] <= '{va: wr_va, size: wr_size, pa: wr_pa, attr: wr_attr,
                           asid: wr_asid, glob: wr_global, vmid: wr_vmid,
                           spc: wr_space};
    end
  end

  always_comb begin
    win      = tab[hit_idx];
    pa_out   = hit ? merge_pa(win.pa, lk_va, win.size) : '0;
    attr_out = hit ? win.attr : '0;
  end

endmodule

// File: rtl/tlb_chk.sv
module tlb_chk #(
  parameter int ENTRIES = 16,
  parameter int ADDR_W  = 48,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               hit,
  input logic               multi_hit,
  input logic [IDX_W-1:0]   hit_idx,
  input logic [ADDR_W-1:0]  pa_out,
  input logic [ADDR_W-1:0]  lk_va,
  input logic [ENTRIES-1:0] match_vec,
  input logic [ENTRIES-1:0] valid_vec,
  input logic [IDX_W-1:0]   victim_idx,
  input logic               victim_free,
  input logic               fill_fire,
  input logic               inv_all
);

  logic [ENTRIES-1:0] below_win;

  always_comb begin
    below_win = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (IDX_W'(i) < hit_idx) below_win[i] = match_vec[i];
    end
  end

  // R1: nothing hits while reset holds
  assert_reset_quiet_R1: assert property (@(posedge clk) !rst_n |-> !hit && !multi_hit);

  // R10: a hit points at a matching entry with no lower match
  assert_win_matches_R10: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> match_vec[hit_idx] && (below_win == '0));

  assert_multi_needs_hit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    multi_hit |-> hit);

  // R3: the low 12 offset bits always pass through
  assert_offset_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> pa_out[11:0] == lk_va[11:0]);

  // R11: invalidate-all empties the array
  assert_flush_all_R11: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> valid_vec == '0);

  // R9: a fill lands in a free slot when one exists and makes it valid
  assert_free_slot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fill_fire && victim_free |-> !valid_vec[victim_idx]);

  assert_fill_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fill_fire |=> valid_vec[$past(victim_idx)]);

endmodule

bind ctx_tlb tlb_chk #(
  .ENTRIES(ENTRIES),
  .ADDR_W (ADDR_W),
  .IDX_W  (IDX_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .hit         (hit),
  .multi_hit   (multi_hit),
  .hit_idx     (hit_idx),
  .pa_out      (pa_out),
  .lk_va       (lk_va),
  .match_vec   (match_vec),
  .valid_vec   (valid_vec),
  .victim_idx  (victim_idx),
  .victim_free (victim_free),
  .fill_fire   (fill_fire),
  .inv_all     (inv_all)
);

// File: tb/tb_ctx_tlb.sv
`timescale 1ns/1ps
module tb_ctx_tlb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic [47:0] lk_va = '0;
  logic        lk_secure = 1'b0;
  logic [1:0]  lk_el = 2'd1;
  logic        lk_top64 = 1'b0;
  logic [15:0] cur_asid = '0;
  logic [7:0]  cur_vmid = '0;
  logic        wr_en = 1'b0;
  logic [47:0] wr_va = '0;
  logic [1:0]  wr_size = '0;
  logic [47:0] wr_pa = '0;
  logic [7:0]  wr_attr = '0;
  logic [15:0] wr_asid = '0;
  logic        wr_global = 1'b0;
  logic [7:0]  wr_vmid = '0;
  logic [1:0]  wr_space = '0;
  logic        inv_all = 1'b0;
  logic        inv_one = 1'b0;
  logic [3:0]  inv_idx = '0;
  logic        hit, multi_hit;
  logic [3:0]  hit_idx;
  logic [47:0] pa_out;
  logic [7:0]  attr_out;

  ctx_tlb dut (.*);

  always #4 clk = ~clk;

  int    n_checks = 0;
  int    n_errors = 0;
  bit    done = 0;
  string cur_tag = "R1";

  task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit          mv  [16];
  logic [47:0] mva [16];
  logic [47:0] mpa [16];
  int          msz [16];
  logic [7:0]  mat [16];
  logic [15:0] mas [16];
  bit          mgl [16];
  logic [7:0]  mvm [16];
  int          msp [16];
  int          rr = 0;

  function automatic int shift_of(int code);
    case (code)
      0: return 12;
      1: return 16;
      2: return 21;
      default: return 30;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (mv[i]) mv[i] = 0;
      rr = 0;
    end else if (inv_all) begin
      foreach (mv[i]) mv[i] = 0;
    end else if (wr_en) begin
      int slot;
      slot = -1;
      for (int i = 0; i < 16; i++) if (!mv[i] && slot < 0) slot = i;
      if (slot < 0) begin
        slot = rr;
        rr = (rr + 1) % 16;
      end
      mv[slot] = 1; mva[slot] = wr_va; mpa[slot] = wr_pa; msz[slot] = int'(wr_size);
      mat[slot] = wr_attr; mas[slot] = wr_asid; mgl[slot] = wr_global;
      mvm[slot] = wr_vmid; msp[slot] = int'(wr_space);
    end else if (inv_one) begin
      mv[inv_idx] = 0;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      int sp, nmatch, first, sh;
      logic [47:0] epa;
      if (lk_el == 2'd3) sp = lk_top64 ? 0 : 2;
      else if (lk_el == 2'd2) sp = 1;
      else sp = lk_secure ? 2 : 3;
      nmatch = 0; first = -1;
      for (int i = 0; i < 16; i++) begin
        bit ok;
        sh = shift_of(msz[i]);
        ok = mv[i] && ((mva[i] >> sh) == (lk_va >> sh)) && (msp[i] == sp);
        if (sp >= 2 && !mgl[i] && mas[i] != cur_asid) ok = 0;
        if (sp == 3 && mvm[i] != cur_vmid) ok = 0;
        if (ok) begin
          nmatch++;
          if (first < 0) first = i;
        end
      end
      check(cur_tag, "model hit", 64'(hit), 64'(nmatch > 0));
      check(cur_tag, "model multi", 64'(multi_hit), 64'(nmatch > 1));
      if (nmatch > 0) begin
        sh  = shift_of(msz[first]);
        epa = ((mpa[first] >> sh) << sh) | (lk_va & ((48'd1 << sh) - 48'd1));
        check(cur_tag, "model idx", 64'(hit_idx), 64'(first));
        check(cur_tag, "model pa", 64'(pa_out), 64'(epa));
        check(cur_tag, "model attr", 64'(attr_out), 64'(mat[first]));
      end else begin
        check(cur_tag, "model pa on miss", 64'(pa_out), 64'd0);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic fill(logic [47:0] va, logic [1:0] sz, logic [47:0] pa, logic [7:0] at,
                      logic [15:0] asid, logic g, logic [7:0] vm, logic [1:0] sp);
    wr_en = 1; wr_va = va; wr_size = sz; wr_pa = pa; wr_attr = at;
    wr_asid = asid; wr_global = g; wr_vmid = vm; wr_space = sp;
    @(posedge clk); #1;
    wr_en = 0; inv_one = 0; inv_all = 0;
  endtask

  task automatic look(string tag, logic [47:0] va, logic sec, logic [1:0] el, logic t64,
                      logic [15:0] asid, logic [7:0] vm,
                      bit eh, int eidx, logic [47:0] epa, bit emul);
    cur_tag = tag;
    lk_va = va; lk_secure = sec; lk_el = el; lk_top64 = t64;
    cur_asid = asid; cur_vmid = vm;
    @(negedge clk); #1;
    check(tag, "hit", 64'(hit), 64'(eh));
    check(tag, "multi", 64'(multi_hit), 64'(emul));
    if (eh) begin
      check(tag, "idx", 64'(hit_idx), 64'(eidx));
      check(tag, "pa", 64'(pa_out), 64'(epa));
    end
    @(posedge clk); #1;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    #2 rst_n = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R1", "hit in reset", 64'(hit), 64'd0);
    check("R1", "multi in reset", 64'(multi_hit), 64'd0);
    rst_n = 1;
    cur_tag = "R1";
    look("R1", 48'h0000_1234_5ABC, 0, 1, 0, 16'd5, 8'd3, 0, 0, 0, 0);

    // slot 0: non-secure user page, 4 KB
    fill(48'h0000_1234_5000, 2'd0, 48'h0000_ABCD_E000, 8'h11, 16'd5, 0, 8'd3, 2'd3);
    look("R3", 48'h0000_1234_5ABC, 0, 1, 0, 16'd5, 8'd3, 1, 0, 48'h0000_ABCD_EABC, 0);
    look("R2", 48'h0000_1234_6ABC, 0, 1, 0, 16'd5, 8'd3, 0, 0, 0, 0);
    look("R5", 48'h0000_1234_5ABC, 0, 1, 0, 16'd6, 8'd3, 0, 0, 0, 0);
    look("R6", 48'h0000_1234_5ABC, 0, 0, 0, 16'd5, 8'd4, 0, 0, 0, 0);
    look("R4", 48'h0000_1234_5ABC, 1, 1, 0, 16'd5, 8'd3, 0, 0, 0, 0);

    // slot 1: global 64 KB page
    fill(48'h0000_2000_0000, 2'd1, 48'h0000_7770_0000, 8'h22, 16'd9, 1, 8'd3, 2'd3);
    look("R5", 48'h0000_2000_F123, 0, 1, 0, 16'd1, 8'd3, 1, 1, 48'h0000_7770_F123, 0);
    look("R2", 48'h0000_2001_0000, 0, 1, 0, 16'd1, 8'd3, 0, 0, 0, 0);
    look("R6", 48'h0000_2000_F123, 0, 1, 0, 16'd1, 8'd7, 0, 0, 0, 0);

    // slot 2: hypervisor 2 MB page
    fill(48'h0000_4000_0000, 2'd2, 48'h0001_0000_0000, 8'h33, 16'd7, 0, 8'd9, 2'd1);
    look("R7", 48'h0000_4001_2345, 0, 2, 0, 16'd0, 8'd0, 1, 2, 48'h0001_0001_2345, 0);
    look("R2", 48'h0000_4020_0000, 0, 2, 0, 16'd0, 8'd0, 0, 0, 0, 0);
    look("R4", 48'h0000_4001_2345, 0, 1, 0, 16'd7, 8'd9, 0, 0, 0, 0);

    // slot 3: secure top level (64-bit) 1 GB page
    fill(48'h0000_C000_0000, 2'd3, 48'h0002_4000_0000, 8'h44, 16'd1, 0, 8'd1, 2'd0);
    look("R7", 48'h0000_C123_4567, 1, 3, 1, 16'h55, 8'h22, 1, 3, 48'h0002_4123_4567, 0);
    look("R4", 48'h0000_C123_4567, 1, 3, 0, 16'd1, 8'd1, 0, 0, 0, 0);
    look("R2", 48'h0001_0000_0000, 1, 3, 1, 16'd1, 8'd1, 0, 0, 0, 0);

    // slot 4: secure user/kernel 4 KB page
    fill(48'h0000_0000_8000, 2'd0, 48'h0000_0009_1000, 8'h55, 16'h20, 0, 8'h40, 2'd2);
    look("R8", 48'h0000_0000_8004, 1, 1, 0, 16'h20, 8'h00, 1, 4, 48'h0000_0009_1004, 0);
    look("R8", 48'h0000_0000_8004, 1, 0, 0, 16'h21, 8'h40, 0, 0, 0, 0);
    look("R8", 48'h0000_0000_8004, 0, 3, 0, 16'h20, 8'h77, 1, 4, 48'h0000_0009_1004, 0);

    // slots 5 and 6: overlapping 1 GB global and 4 KB pages
    fill(48'h0000_0000_0000, 2'd3, 48'h0000_8000_0000, 8'h66, 16'd0, 1, 8'd3, 2'd3);
    fill(48'h0000_0000_3000, 2'd0, 48'h0000_0004_4000, 8'h77, 16'd5, 0, 8'd3, 2'd3);
    look("R10", 48'h0000_0000_3010, 0, 1, 0, 16'd5, 8'd3, 1, 5, 48'h0000_8000_3010, 1);
    look("R10", 48'h0000_0000_3010, 0, 1, 0, 16'd6, 8'd3, 1, 5, 48'h0000_8000_3010, 0);

    // single invalidate of slot 5, then refill lands there
    inv_one = 1; inv_idx = 4'd5;
    @(posedge clk); #1; inv_one = 0;
    look("R12", 48'h0000_0000_3010, 0, 1, 0, 16'd5, 8'd3, 1, 6, 48'h0000_0004_4010, 0);
    fill(48'h0000_0000_3000, 2'd0, 48'h0000_0000_A000, 8'h88, 16'd5, 0, 8'd3, 2'd3);
    look("R9", 48'h0000_0000_3010, 0, 1, 0, 16'd5, 8'd3, 1, 5, 48'h0000_0000_A010, 1);

    // invalidate of slot 0 in the same cycle as a fill is ignored
    inv_one = 1; inv_idx = 4'd0;
    fill(48'h0000_0DDD_D000, 2'd0, 48'h0000_0EEE_E000, 8'h99, 16'd5, 0, 8'd3, 2'd3);
    look("R12", 48'h0000_1234_5ABC, 0, 1, 0, 16'd5, 8'd3, 1, 0, 48'h0000_ABCD_EABC, 0);
    look("R9", 48'h0000_0DDD_D123, 0, 1, 0, 16'd5, 8'd3, 1, 7, 48'h0000_0EEE_E123, 0);

    // fill slots 8..15, then the round-robin pointer takes over
    for (int k = 0; k < 8; k++)
      fill(48'h0001_0000_0000 + 48'(k) * 48'h1000, 2'd0, 48'h0003_0000_0000 + 48'(k) * 48'h1000,
           8'(k), 16'd5, 0, 8'd3, 2'd3);
    look("R9", 48'h0001_0000_7008, 0, 1, 0, 16'd5, 8'd3, 1, 15, 48'h0003_0000_7008, 0);
    fill(48'h0002_0000_0000, 2'd0, 48'h0004_0000_0000, 8'hA0, 16'd5, 0, 8'd3, 2'd3);
    look("R9", 48'h0002_0000_0010, 0, 1, 0, 16'd5, 8'd3, 1, 0, 48'h0004_0000_0010, 0);
    look("R9", 48'h0000_1234_5ABC, 0, 1, 0, 16'd5, 8'd3, 0, 0, 0, 0);
    fill(48'h0002_0000_1000, 2'd0, 48'h0004_0000_1000, 8'hA1, 16'd5, 0, 8'd3, 2'd3);
    look("R9", 48'h0002_0000_1010, 0, 1, 0, 16'd5, 8'd3, 1, 1, 48'h0004_0000_1010, 0);

    // invalidate-all beats a same-cycle fill
    inv_all = 1;
    fill(48'h0005_0000_0000, 2'd0, 48'h0005_0000_0000, 8'hB0, 16'd5, 0, 8'd3, 2'd3);
    look("R11", 48'h0005_0000_0000, 0, 1, 0, 16'd5, 8'd3, 0, 0, 0, 0);
    look("R11", 48'h0001_0000_7008, 0, 1, 0, 16'd5, 8'd3, 0, 0, 0, 0);
    fill(48'h0006_0000_0000, 2'd1, 48'h0007_0000_0000, 8'hC0, 16'd5, 0, 8'd3, 2'd3);
    look("R9", 48'h0006_0000_ABCD, 0, 1, 0, 16'd5, 8'd3, 1, 0, 48'h0007_0000_ABCD, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule